// File: doc/BRIEF.md
# Interleaved Periodic Converter Sequencer

This block services one or two parallel-output analog-to-digital converters on a fixed schedule and never waits for a conversion to finish. A programmable period counter produces service points at regular intervals. At each service point the block reads the result of the conversion it launched earlier, and then launches the next conversion on the same converter. Between service points the block does nothing and waits on no converter.

In single mode only converter 0 is used, and every sample lags its start by one interval. In dual mode the service points alternate between converter 0 and converter 1. Each converter is therefore restarted every second interval, and one converter is still converting while the other is launched. Each captured result leaves the block as a single-cycle valid pulse with the data and a channel bit. If a converter has not signalled completion by the time its result is read, a sticky overrun flag is set and the stale result is still sent out.

Top module: `adc_svc_seq`

## Requirements
- R1: While reset is held, and for the two clocks after it is released, every output is low: start, read, valid, channel, data and overrun.
- R2: Service points come exactly `period_cfg` clocks apart. Starts are therefore spaced exactly `period_cfg` clocks apart whatever the converters do.
- R3: At a service point the read strobe of the selected converter is high for one clock. On the next clock the start strobe of that same converter is high. At most one read bit and one start bit are ever high.
- R4: The first service of a converter after reset issues a start with no read and produces no sample. Over a run, single mode gives one sample fewer than starts, and dual mode gives two fewer.
- R5: A sample carries the converter result present on the clock its read strobe is high, and it appears on the next clock together with the start. That result belongs to the conversion started at that converter's previous service.
- R6: With `dual_en` low, only converter 0 (bit 0 of the start and read buses) is ever started or read, and every sample has channel 0.
- R7: With `dual_en` high, the services alternate 0, 1, 0, 1 starting from converter 0. Each sample's channel bit (0 or 1) names the converter that was read.
- R8: If a converter's done input has not been high at any point since its last start, up to and including its read clock, `overrun` is set at the capture and stays set until reset. The stale result is still output.
- R9: The start bits and `smp_valid` are each high for exactly one clock per service.
- R10: A `period_cfg` value of 0 or 1 is treated as 2.
- R11: An overrun does not delay the schedule. Services, starts and samples keep their spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cfg | input | PER_W | Service interval in clocks (minimum 2) |
| dual_en | input | 1 | High: alternate two converters |
| cv_done | input | 2 | Conversion-complete level, one bit per converter |
| cv_res0 | input | DATA_W | Parallel result of converter 0 |
| cv_res1 | input | DATA_W | Parallel result of converter 1 |
| cv_start | output | 2 | One-clock start strobe per converter |
| cv_read | output | 2 | One-clock read strobe per converter |
| smp_valid | output | 1 | Sample valid pulse |
| smp_chan | output | 1 | Converter that produced the sample |
| smp_data | output | DATA_W | Sample value |
| overrun | output | 1 | Sticky: a result was read before its conversion ended |

## Verification
The bench targets the first service after reset, the minimum period, and a conversion time that is longer than one interval but shorter than two, which only dual mode tolerates.

A design that read before the first start would emit a zero sample and break the sample-to-start count. A design that forgot the pending state of the second converter would emit two spurious samples in dual mode. A design that waited on done, or that clamped the period wrongly, would show start spacing that drifts from the programmed interval. A design that cleared its done record at the wrong edge would raise overrun in the dual-mode run, or would fail to raise it in the slow single-mode run.

// File: rtl/adc_svc_pkg.sv
package adc_svc_pkg;
  localparam int NCONV = 2;
  typedef logic [NCONV-1:0] conv_vec_t;

  function automatic conv_vec_t sel_to_vec(input logic s);
    return s ? conv_vec_t'(2'b10) : conv_vec_t'(2'b01);
  endfunction
endpackage

// File: rtl/adc_svc_rst_sync.sv
module adc_svc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/adc_svc_ticker.sv
module adc_svc_ticker #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_cfg,
  output logic             tick
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);

  logic [PER_W-1:0] cnt_q, cnt_nxt, lim;

  always_comb begin
    lim     = (period_cfg < MIN_PER) ? (MIN_PER - PER_W'(1)) : (period_cfg - PER_W'(1));
    tick    = (cnt_q >= lim);
    cnt_nxt = tick ? '0 : cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/adc_svc_track.sv
module adc_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic done_i,
  output logic pend_o,
  output logic ready_o
);
  logic seen_q, seen_nxt, pend_q, pend_nxt;

  always_comb begin
    seen_nxt = launch_i ? 1'b0 : (seen_q | done_i);
    pend_nxt = pend_q | launch_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      seen_q <= seen_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign pend_o  = pend_q;
  assign ready_o = seen_q | done_i;
endmodule

// File: rtl/adc_svc_seq.sv
module adc_svc_seq
  import adc_svc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  period_cfg,
  input  logic              dual_en,
  input  logic [1:0]        cv_done,
  input  logic [DATA_W-1:0] cv_res0,
  input  logic [DATA_W-1:0] cv_res1,
  output logic [1:0]        cv_start,
  output logic [1:0]        cv_read,
  output logic              smp_valid,
  output logic              smp_chan,
  output logic [DATA_W-1:0] smp_data,
  output logic              overrun
);
  logic srst_n, tick;
  logic [DATA_W-1:0] res_arr [NCONV];
  conv_vec_t pend, ready, launch, sel_vec;

  logic      stage_q, stage_nxt;
  logic      sel_q, sel_nxt;
  conv_vec_t rd_q, rd_nxt, st_q, st_nxt;
  logic      val_q, val_nxt, chan_q, chan_nxt, ovr_q, ovr_nxt;
  logic [DATA_W-1:0] data_q, data_nxt;
  logic      data_en;

  assign res_arr[0] = cv_res0;
  assign res_arr[1] = cv_res1;

  adc_svc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  adc_svc_ticker #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(srst_n), .period_cfg(period_cfg), .tick(tick)
  );

  for (genvar g = 0; g < NCONV; g++) begin : g_trk
    adc_svc_track u_trk (
      .clk(clk), .rst_n(srst_n), .launch_i(launch[g]), .done_i(cv_done[g]),
      .pend_o(pend[g]), .ready_o(ready[g])
    );
  end

  always_comb begin
    sel_vec   = sel_to_vec(sel_q);
    launch    = stage_q ? sel_vec : '0;
    stage_nxt = tick;
    rd_nxt    = tick ? (sel_vec & pend) : '0;
    data_en   = stage_q;
    data_nxt  = res_arr[sel_q];
    val_nxt   = 1'b0;
    st_nxt    = '0;
    chan_nxt  = chan_q;
    ovr_nxt   = ovr_q;
    sel_nxt   = sel_q;
    if (stage_q) begin
      val_nxt  = |rd_q;
      st_nxt   = sel_vec;
      chan_nxt = sel_q;
      ovr_nxt  = ovr_q | (|(rd_q & ~ready));
      sel_nxt  = dual_en & ~sel_q;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      stage_q <= 1'b0;
      sel_q   <= 1'b0;
      rd_q    <= '0;
      st_q    <= '0;
      val_q   <= 1'b0;
      chan_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      stage_q <= stage_nxt;
      sel_q   <= sel_nxt;
      rd_q    <= rd_nxt;
      st_q    <= st_nxt;
      val_q   <= val_nxt;
      chan_q  <= chan_nxt;
      ovr_q   <= ovr_nxt;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      data_q <= '0;
    else if (data_en) data_q <= data_nxt;
  end

  assign cv_start  = st_q;
  assign cv_read   = rd_q;
  assign smp_valid = val_q;
  assign smp_chan  = chan_q;
  assign smp_data  = data_q;
  assign overrun   = ovr_q;
endmodule

// File: rtl/adc_svc_chk.sv
module adc_svc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] start_v,
  input logic [1:0] rd_v,
  input logic       valid,
  input logic       chan,
  input logic       ovr
);
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_v)); // R3
  AST_READ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_v)); // R3
  AST_READ_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_v) |=> (start_v == $past(rd_v))); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_v) |=> (start_v == 2'b00)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R9
  AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(rd_v) == (chan ? 2'b10 : 2'b01))); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr); // R8
endmodule

bind adc_svc_seq adc_svc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_v(cv_start), .rd_v(cv_read),
  .valid(smp_valid), .chan(smp_chan), .ovr(overrun)
);

// File: tb/sim_adc_svc_seq.sv
module sim_adc_svc_seq;
  localparam int DW = 12;
  localparam int PW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [PW-1:0] period_cfg = PW'(8);
  logic          dual_en = 1'b0;
  logic [1:0]    cv_done = 2'b00;
  logic [DW-1:0] cv_res0 = '0, cv_res1 = '0;
  logic [1:0]    cv_start, cv_read;
  logic          smp_valid, smp_chan, overrun;
  logic [DW-1:0] smp_data;

  adc_svc_seq #(.DATA_W(DW), .PER_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .dual_en(dual_en),
    .cv_done(cv_done), .cv_res0(cv_res0), .cv_res1(cv_res1),
    .cv_start(cv_start), .cv_read(cv_read), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .overrun(overrun)
  );

  integer checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // converter emulation
  integer conv_cyc [2];
  integer busy [2];
  logic [DW-1:0] nxt_val [2];
  integer seq = 1;
  always @(negedge clk) begin
    if (!rst_n) begin
      busy[0] = 0; busy[1] = 0;
      cv_done = 2'b00; cv_res0 = '0; cv_res1 = '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (cv_start[c]) begin
          busy[c] = conv_cyc[c];
          cv_done[c] = 1'b0;
          nxt_val[c] = DW'((c << 8) | (seq & 8'hFF));
          seq++;
        end else if (busy[c] > 0) begin
          busy[c] = busy[c] - 1;
          if (busy[c] == 0) begin
            cv_done[c] = 1'b1;
            if (c == 0) cv_res0 = nxt_val[0];
            else        cv_res1 = nxt_val[1];
          end
        end
      end
    end
  end

  // behavioural reference model
  integer rel, m_cnt, eff;
  bit m_stage, m_sel, m_ovr, m_valid, m_chan, tk;
  bit m_pend [2];
  bit m_seen [2];
  logic [1:0] m_rd, m_start;
  logic [DW-1:0] m_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; m_cnt = 0; m_stage = 0; m_sel = 0; m_ovr = 0;
      m_valid = 0; m_chan = 0; m_rd = 0; m_start = 0; m_data = '0;
      m_pend[0] = 0; m_pend[1] = 0; m_seen[0] = 0; m_seen[1] = 0;
    end else begin
      rel++;
      if (rel >= 3) begin
        eff = (period_cfg < 2) ? 2 : int'(period_cfg);
        tk  = (m_cnt >= eff - 1);
        m_cnt = tk ? 0 : m_cnt + 1;
        for (int c = 0; c < 2; c++) m_seen[c] = m_seen[c] | cv_done[c];
        if (m_stage) begin
          m_valid = (m_rd != 0);
          m_data  = m_sel ? cv_res1 : cv_res0;
          m_chan  = m_sel;
          m_start = m_sel ? 2'b10 : 2'b01;
          if (m_rd != 0 && !m_seen[m_sel]) m_ovr = 1;
          m_pend[m_sel] = 1;
          m_seen[m_sel] = 0;
          m_sel = dual_en ? !m_sel : 1'b0;
        end else begin
          m_valid = 0;
          m_start = 0;
        end
        m_rd = (tk && m_pend[m_sel]) ? (m_sel ? 2'b10 : 2'b01) : 2'b00;
        m_stage = tk;
      end
    end
  end

  // per-cycle comparison and scenario statistics
  integer cyc, n_st, n_val, last_st, last_ch, last_vch, gap_bad, alt_bad, valt_bad, ch1_use, exp_gap;
  logic [DW-1:0] last_data;
  task automatic clear_stats(input integer gap);
    cyc = 0; n_st = 0; n_val = 0; last_st = -1; last_ch = -1; last_vch = -1;
    gap_bad = 0; alt_bad = 0; valt_bad = 0; ch1_use = 0; exp_gap = gap;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      chk(cv_start == m_start, "R3 start", cv_start, m_start);
      chk(cv_read == m_rd, "R3 read", cv_read, m_rd);
      chk(smp_valid == m_valid, "R9 valid", smp_valid, m_valid);
      chk(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
      if (m_valid) begin
        chk(smp_chan == m_chan, "R7 chan", smp_chan, m_chan);
        chk(smp_data == m_data, "R5 data", smp_data, m_data);
      end
      if (|cv_start) begin
        if (last_st >= 0 && (cyc - last_st) != exp_gap) gap_bad++;
        if (dual_en && last_ch == int'(cv_start[1])) alt_bad++;
        last_st = cyc; last_ch = int'(cv_start[1]); n_st++;
      end
      if (cv_start[1] || cv_read[1] || (smp_valid && smp_chan)) ch1_use++;
      if (smp_valid) begin
        if (dual_en && last_vch == int'(smp_chan)) valt_bad++;
        last_vch = int'(smp_chan); n_val++; last_data = smp_data;
      end
    end
  end

  task automatic do_reset(input integer per, input bit dual, input integer c0, input integer c1);
    @(negedge clk);
    rst_n = 1'b0;
    period_cfg = PW'(per); dual_en = dual;
    conv_cyc[0] = c0; conv_cyc[1] = c1;
    repeat (3) @(negedge clk);
    chk({cv_start, cv_read, smp_valid, smp_chan, overrun} == 0 && smp_data == 0, "R1 in reset",
        {cv_start, cv_read, smp_valid, smp_chan, overrun}, 0);
    clear_stats((per < 2) ? 2 : per);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cv_start, cv_read, smp_valid, overrun} == 0, "R1 after release", {cv_start, cv_read, smp_valid, overrun}, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // single mode, conversion shorter than interval
    do_reset(8, 1'b0, 5, 5);
    repeat (90) @(negedge clk);
    chk(n_st >= 8, "R2 starts issued", n_st, 8);
    chk(gap_bad == 0, "R2 start spacing", gap_bad, 0);
    chk(n_val == n_st - 1, "R4 single first service", n_val, n_st - 1);
    chk(ch1_use == 0, "R6 converter 1 idle", ch1_use, 0);
    chk(overrun == 0, "R8 no overrun", overrun, 0);

    // dual mode, conversion longer than one interval
    do_reset(6, 1'b1, 9, 9);
    repeat (100) @(negedge clk);
    chk(alt_bad == 0, "R7 start alternation", alt_bad, 0);
    chk(valt_bad == 0, "R7 sample channel alternation", valt_bad, 0);
    chk(n_val == n_st - 2, "R4 dual first services", n_val, n_st - 2);
    chk(gap_bad == 0, "R2 dual spacing", gap_bad, 0);
    chk(overrun == 0, "R8 overlap without overrun", overrun, 0);

    // single mode, conversion too slow
    do_reset(6, 1'b0, 9, 9);
    repeat (70) @(negedge clk);
    chk(overrun == 1, "R8 overrun raised", overrun, 1);
    chk(last_data == 0, "R8 stale value output", last_data, 0);
    chk(gap_bad == 0, "R11 schedule kept", gap_bad, 0);
    chk(n_val == n_st - 1, "R11 samples kept", n_val, n_st - 1);

    // period clamp
    do_reset(0, 1'b0, 1, 1);
    repeat (40) @(negedge clk);
    chk(gap_bad == 0 && n_st >= 15, "R10 period 0 as 2", n_st, 15);
    chk(overrun == 0, "R10 no overrun at minimum", overrun, 0);
    do_reset(1, 1'b1, 1, 1);
    repeat (40) @(negedge clk);
    chk(gap_bad == 0 && n_st >= 15, "R10 period 1 as 2", n_st, 15);
    chk(valt_bad == 0, "R7 alternation at minimum", valt_bad, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule